// File: doc/BRIEF.md
# Send DMA Engine Lifecycle Controller

This block sequences a send DMA engine between being powered down, starting up, sitting idle, streaming, and the three-stage recovery path (wait for halt, hardware clean-up, software clean-up) that follows a stop or an error. Software and hardware report conditions to it as single-cycle event strobes on one vector. It answers with a registered state, a per-state set of engine control levels, and single-cycle request pulses. The pulses ask neighbouring logic to restart the engine, to clean the hardware, or to clean the software queue. That neighbouring logic reports back with the matching completion event.

A sticky "want running" flag records whether the engine should stream once start-up finishes. Go-running and go-idle events update the flag while the controller waits in any recovery state. Two error-halt events are accepted. The first goes straight to software clean-up. The second takes the longer route through the halt-wait and hardware clean-up states. The previous state and the index of the last accepted event are kept for debug readout.

All outputs are registered. An event sampled at a clock edge takes effect on the state, the flag and the request pulses at that same edge.

Top module: `sdma_ctrl_fsm`

## Requirements
- R1: After reset: state_o is 0 (down), want_run_o is 0, all request pulses are 0, prev_state_o is 0 and last_evt_o is 15. The state codes are: down 0, start-up wait 1, idle 2, software clean-up wait 3, hardware clean-up wait 4, halt wait 5, running 6.
- R2: The bits of evt_i are: 0 go-down, 1 go-start, 2 hw-started, 3 go-running, 4 sw-cleaned, 5 hw-cleaned, 6 hw-halted, 7 go-idle, 8 error-halt A, 9 error-halt B, 10 timer tick. When several bits are set, only the lowest-numbered one is acted on. An all-zero vector is no event.
- R3: In down, go-start moves to start-up wait. Go-running also moves to start-up wait and sets want_run_o.
- R4: In start-up wait, hw-started moves to running if want_run_o is 1, and to idle otherwise.
- R5: In idle, go-running moves to running and sets want_run_o. In running, go-idle moves to halt wait and clears want_run_o.
- R6: In running, hw-halted or error-halt A moves to software clean-up wait and pulses sw_clean_req_o. Error-halt B moves to halt wait.
- R7: In halt wait, hw-halted moves to hardware clean-up wait and pulses hw_clean_req_o. In hardware clean-up wait, hw-cleaned moves to software clean-up wait and pulses sw_clean_req_o. In software clean-up wait, sw-cleaned moves to start-up wait and pulses start_req_o.
- R8: In start-up wait, software clean-up wait, hardware clean-up wait and halt wait, go-running sets want_run_o and go-idle clears it, and the state does not change.
- R9: Go-down moves every state to down. It pulses sw_clean_req_o only when leaving running, halt wait or hardware clean-up wait.
- R10: Timer tick, and any event not listed for the current state, leaves the state and want_run_o unchanged and produces no request pulse.
- R11: eng_en_o and eng_irq_en_o are 1 only in running. eng_halt_o is 1 in down, halt wait and both clean-up waits. eng_drain_o is 1 only in halt wait.
- R12: Each request pulse lasts one cycle, appears in the cycle in which the state changes, and at most one pulse is high at a time.
- R13: On each state change, prev_state_o takes the state that was left. On each accepted event, last_evt_o takes the event's bit index, including events that change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 11 | Event strobes, one bit per event |
| state_o | output | 3 | Current state code |
| want_run_o | output | 1 | Sticky want-running flag |
| eng_en_o | output | 1 | Engine enable |
| eng_irq_en_o | output | 1 | Engine interrupt enable |
| eng_halt_o | output | 1 | Engine halt |
| eng_drain_o | output | 1 | Engine drain |
| start_req_o | output | 1 | Start-up request pulse |
| hw_clean_req_o | output | 1 | Hardware clean-up request pulse |
| sw_clean_req_o | output | 1 | Software clean-up request pulse |
| prev_state_o | output | 3 | State left at the last transition |
| last_evt_o | output | 4 | Bit index of the last accepted event, 15 after reset |

## Verification
The bench builds the block with its default parameters: eleven event bits and a four-bit event index. With these values every event reaches every state, and the reset value 15 of the debug index cannot be mistaken for a real event. A directed walk covers each transition and both error-halt routes. It then changes the want-running flag inside the recovery states and checks that this decides between idle and running at start-up completion. A long stream of single and multi-bit events follows, which exercises the priority rule and the ignored events in every state.

// File: rtl/sdma_ctrl_pkg.sv
package sdma_ctrl_pkg;
  localparam int NUM_EVT   = 11;
  localparam int EVT_IDX_W = $clog2(NUM_EVT + 1);
  localparam logic [EVT_IDX_W-1:0] EVT_NONE = '1;

  localparam int EV_DOWN     = 0;
  localparam int EV_START    = 1;
  localparam int EV_STARTED  = 2;
  localparam int EV_RUN      = 3;
  localparam int EV_SW_DONE  = 4;
  localparam int EV_HW_DONE  = 5;
  localparam int EV_HALTED   = 6;
  localparam int EV_IDLE     = 7;
  localparam int EV_ERR_A    = 8;
  localparam int EV_ERR_B    = 9;
  localparam int EV_TICK     = 10;

  typedef enum logic [2:0] {
    ST_DOWN      = 3'd0,
    ST_STARTUP   = 3'd1,
    ST_IDLE      = 3'd2,
    ST_SW_CLEAN  = 3'd3,
    ST_HW_CLEAN  = 3'd4,
    ST_HALT_WAIT = 3'd5,
    ST_RUN       = 3'd6
  } ctl_state_e;
endpackage

// File: rtl/sdma_evt_pick.sv
module sdma_evt_pick #(
  parameter int N = 11,
  parameter int W = 4
) (
  input  logic [N-1:0] evt_i,
  output logic         vld_o,
  output logic [W-1:0] idx_o
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    vld_o = 1'b0;
    idx_o = '1;
    for (int k = N - 1; k >= 0; k--) begin
      if (evt_i[k]) begin
        vld_o = 1'b1;
        idx_o = W'(k);
      end
    end
  end
endmodule

// File: rtl/sdma_ctl_table.sv
module sdma_ctl_table
  import sdma_ctrl_pkg::*;
(
  input  ctl_state_e st_i,
  output logic       en_o,
  output logic       irq_en_o,
  output logic       halt_o,
  output logic       drain_o
);
  always_comb begin
    en_o     = 1'b0;
    irq_en_o = 1'b0;
    halt_o   = 1'b0;
    drain_o  = 1'b0;
    case (st_i)
      ST_RUN: begin
        en_o     = 1'b1;
        irq_en_o = 1'b1;
      end
      ST_HALT_WAIT: begin
        halt_o  = 1'b1;
        drain_o = 1'b1;
      end
      ST_DOWN, ST_SW_CLEAN, ST_HW_CLEAN: halt_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sdma_dbg_regs.sv
module sdma_dbg_regs
  import sdma_ctrl_pkg::*;
#(
  parameter int W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ctl_state_e cur_i,
  input  ctl_state_e nxt_i,
  input  logic       evt_vld_i,
  input  logic [W-1:0] evt_idx_i,
  output logic [2:0] prev_o,
  output logic [W-1:0] last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_o <= ST_DOWN;
      last_o <= '1;
    end else begin
      if (nxt_i != cur_i) prev_o <= cur_i;
      if (evt_vld_i)      last_o <= evt_idx_i;
    end
  end
endmodule

// File: rtl/sdma_ctrl_fsm.sv
module sdma_ctrl_fsm
  import sdma_ctrl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_EVT-1:0]   evt_i,
  output logic [2:0]           state_o,
  output logic                 want_run_o,
  output logic                 eng_en_o,
  output logic                 eng_irq_en_o,
  output logic                 eng_halt_o,
  output logic                 eng_drain_o,
  output logic                 start_req_o,
  output logic                 hw_clean_req_o,
  output logic                 sw_clean_req_o,
  output logic [2:0]           prev_state_o,
  output logic [EVT_IDX_W-1:0] last_evt_o
);
  ctl_state_e st_q, st_d;
  logic want_q, want_d;
  logic rq_start_d, rq_hw_d, rq_sw_d;
  logic rq_start_q, rq_hw_q, rq_sw_q;
  logic evt_vld;
  logic [EVT_IDX_W-1:0] evt_idx;

  sdma_evt_pick #(.N(NUM_EVT), .W(EVT_IDX_W)) u_pick (
    .evt_i (evt_i),
    .vld_o (evt_vld),
    .idx_o (evt_idx)
  );

  function automatic logic is_wait(ctl_state_e s);
    return (s == ST_STARTUP) || (s == ST_SW_CLEAN) ||
           (s == ST_HW_CLEAN) || (s == ST_HALT_WAIT);
  endfunction

  always_comb begin
    st_d       = st_q;
    want_d     = want_q;
    rq_start_d = 1'b0;
    rq_hw_d    = 1'b0;
    rq_sw_d    = 1'b0;
    if (evt_vld) begin
      if (int'(evt_idx) == EV_DOWN) begin
        st_d    = ST_DOWN;
        rq_sw_d = (st_q == ST_RUN) || (st_q == ST_HALT_WAIT) || (st_q == ST_HW_CLEAN);
      end else if (is_wait(st_q) && int'(evt_idx) == EV_RUN) begin
        want_d = 1'b1;
      end else if (is_wait(st_q) && int'(evt_idx) == EV_IDLE) begin
        want_d = 1'b0;
      end else begin
        case (st_q)
          ST_DOWN:
            if (int'(evt_idx) == EV_START) st_d = ST_STARTUP;
            else if (int'(evt_idx) == EV_RUN) begin
              st_d   = ST_STARTUP;
              want_d = 1'b1;
            end
          ST_STARTUP:
            if (int'(evt_idx) == EV_STARTED) st_d = want_q ? ST_RUN : ST_IDLE;
          ST_IDLE:
            if (int'(evt_idx) == EV_RUN) begin
              st_d   = ST_RUN;
              want_d = 1'b1;
            end
          ST_RUN:
            if (int'(evt_idx) == EV_IDLE) begin
              st_d   = ST_HALT_WAIT;
              want_d = 1'b0;
            end else if (int'(evt_idx) == EV_HALTED || int'(evt_idx) == EV_ERR_A) begin
              st_d    = ST_SW_CLEAN;
              rq_sw_d = 1'b1;
            end else if (int'(evt_idx) == EV_ERR_B) begin
              st_d = ST_HALT_WAIT;
            end
          ST_HALT_WAIT:
            if (int'(evt_idx) == EV_HALTED) begin
              st_d    = ST_HW_CLEAN;
              rq_hw_d = 1'b1;
            end
          ST_HW_CLEAN:
            if (int'(evt_idx) == EV_HW_DONE) begin
              st_d    = ST_SW_CLEAN;
              rq_sw_d = 1'b1;
            end
          ST_SW_CLEAN:
            if (int'(evt_idx) == EV_SW_DONE) begin
              st_d       = ST_STARTUP;
              rq_start_d = 1'b1;
            end
          default: st_d = ST_DOWN;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_DOWN;
      want_q     <= 1'b0;
      rq_start_q <= 1'b0;
      rq_hw_q    <= 1'b0;
      rq_sw_q    <= 1'b0;
    end else begin
      st_q       <= st_d;
      want_q     <= want_d;
      rq_start_q <= rq_start_d;
      rq_hw_q    <= rq_hw_d;
      rq_sw_q    <= rq_sw_d;
    end
  end

  sdma_ctl_table u_tbl (
    .st_i     (st_q),
    .en_o     (eng_en_o),
    .irq_en_o (eng_irq_en_o),
    .halt_o   (eng_halt_o),
    .drain_o  (eng_drain_o)
  );

  sdma_dbg_regs #(.W(EVT_IDX_W)) u_dbg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cur_i     (st_q),
    .nxt_i     (st_d),
    .evt_vld_i (evt_vld),
    .evt_idx_i (evt_idx),
    .prev_o    (prev_state_o),
    .last_o    (last_evt_o)
  );

  assign state_o        = st_q;
  assign want_run_o     = want_q;
  assign start_req_o    = rq_start_q;
  assign hw_clean_req_o = rq_hw_q;
  assign sw_clean_req_o = rq_sw_q;

  assert_req_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_req_o, hw_clean_req_o, sw_clean_req_o}));

  assert_sw_req_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clean_req_o |=> !sw_clean_req_o);

  assert_start_from_swclean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o |-> (st_q == ST_STARTUP && prev_state_o == 3'(ST_SW_CLEAN)));

  assert_tick_no_effect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == NUM_EVT'(1) << EV_TICK) |=> ($stable(st_q) && $stable(want_q) &&
      !start_req_o && !hw_clean_req_o && !sw_clean_req_o));

  assert_down_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[EV_DOWN] |=> (st_q == ST_DOWN));

  assert_enable_only_run_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_en_o || eng_irq_en_o) |-> (state_o == 3'(ST_RUN)));
endmodule

// File: tb/sdma_ctrl_fsm_bench.sv
`timescale 1ns/1ps
module sdma_ctrl_fsm_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] evt = '0;
  logic [2:0] state_o, prev_state_o;
  logic [3:0] last_evt_o;
  logic want_run_o, eng_en_o, eng_irq_en_o, eng_halt_o, eng_drain_o;
  logic start_req_o, hw_clean_req_o, sw_clean_req_o;

  always #2 clk = ~clk;

  sdma_ctrl_fsm u_sdma_ctrl_fsm (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .state_o(state_o), .want_run_o(want_run_o),
    .eng_en_o(eng_en_o), .eng_irq_en_o(eng_irq_en_o),
    .eng_halt_o(eng_halt_o), .eng_drain_o(eng_drain_o),
    .start_req_o(start_req_o), .hw_clean_req_o(hw_clean_req_o),
    .sw_clean_req_o(sw_clean_req_o),
    .prev_state_o(prev_state_o), .last_evt_o(last_evt_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int m_st = 0, m_prev = 0, m_last = 15;
  bit m_want = 0, m_rs = 0, m_rh = 0, m_rw = 0;
  string m_tag = "R1";

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(m_tag, "state", int'(state_o), m_st);
    chk(m_tag, "want_run", int'(want_run_o), int'(m_want));
    chk(m_tag == "R1" ? "R1" : "R12", "start_req", int'(start_req_o), int'(m_rs));
    chk(m_tag == "R1" ? "R1" : "R12", "hw_clean_req", int'(hw_clean_req_o), int'(m_rh));
    chk(m_tag == "R1" ? "R1" : "R12", "sw_clean_req", int'(sw_clean_req_o), int'(m_rw));
    chk("R11", "enable", int'(eng_en_o), int'(m_st == 6));
    chk("R11", "irq_enable", int'(eng_irq_en_o), int'(m_st == 6));
    chk("R11", "halt", int'(eng_halt_o), int'(m_st == 0 || m_st == 3 || m_st == 4 || m_st == 5));
    chk("R11", "drain", int'(eng_drain_o), int'(m_st == 5));
    chk(m_tag == "R1" ? "R1" : "R13", "prev_state", int'(prev_state_o), m_prev);
    chk(m_tag == "R1" ? "R1" : "R13", "last_evt", int'(last_evt_o), m_last);
  endtask

  // reference model: event index per bit list in R2, state codes per R1
  task automatic model(logic [10:0] e);
    int ix = -1;
    int ns;
    bit wait_st;
    m_rs = 0; m_rh = 0; m_rw = 0;
    for (int k = 10; k >= 0; k--) if (e[k]) ix = k;
    m_tag = "R10";
    if (ix < 0) return;
    m_last = ix;
    ns = m_st;
    wait_st = (m_st == 1 || m_st == 3 || m_st == 4 || m_st == 5);
    if (ix == 0) begin
      m_tag = "R9"; ns = 0;
      m_rw = (m_st == 6 || m_st == 5 || m_st == 4);
    end else if (wait_st && ix == 3) begin
      m_tag = "R8"; m_want = 1;
    end else if (wait_st && ix == 7) begin
      m_tag = "R8"; m_want = 0;
    end else if (m_st == 0 && ix == 1) begin
      m_tag = "R3"; ns = 1;
    end else if (m_st == 0 && ix == 3) begin
      m_tag = "R3"; ns = 1; m_want = 1;
    end else if (m_st == 1 && ix == 2) begin
      m_tag = "R4"; ns = m_want ? 6 : 2;
    end else if (m_st == 2 && ix == 3) begin
      m_tag = "R5"; ns = 6; m_want = 1;
    end else if (m_st == 6 && ix == 7) begin
      m_tag = "R5"; ns = 5; m_want = 0;
    end else if (m_st == 6 && (ix == 6 || ix == 8)) begin
      m_tag = "R6"; ns = 3; m_rw = 1;
    end else if (m_st == 6 && ix == 9) begin
      m_tag = "R6"; ns = 5;
    end else if (m_st == 5 && ix == 6) begin
      m_tag = "R7"; ns = 4; m_rh = 1;
    end else if (m_st == 4 && ix == 5) begin
      m_tag = "R7"; ns = 3; m_rw = 1;
    end else if (m_st == 3 && ix == 4) begin
      m_tag = "R7"; ns = 1; m_rs = 1;
    end
    if ($countones(e) > 1) m_tag = "R2";
    if (ns != m_st) begin
      m_prev = m_st;
      m_st = ns;
    end
  endtask

  task automatic step(logic [10:0] e);
    evt = e;
    model(e);
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [10:0] bit_of(int i);
    return 11'(1) << i;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    m_tag = "R1";
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    step(bit_of(1));  step(bit_of(2));  step(bit_of(3));  step(bit_of(10));
    step(bit_of(7));  step(bit_of(6));  step(bit_of(3));  step(bit_of(5));
    step(bit_of(7));  step(bit_of(4));  step(bit_of(2));  step(bit_of(3));
    step(bit_of(8));  step(bit_of(4));  step(bit_of(2));  step(bit_of(9));
    step(bit_of(0));  step(bit_of(3));  step(bit_of(0));  step(bit_of(4));
    step(bit_of(3) | bit_of(6));  step(bit_of(10)); step('0);
    step(bit_of(2));  step(bit_of(6) | bit_of(8));
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom % 16;
      if (r < 11)       step(bit_of(r));
      else if (r < 14)  step(11'($urandom));
      else              step('0);
    end
    evt = '0;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule